// File: doc/BRIEF.md
# Glitch Suppression Filter

This block cleans a sampled single-bit signal by discarding any pulse that lasts for only one sample. The output level is changed only after the input has presented the opposite level on two enabled samples in a row. A single stray sample of either polarity is absorbed, so the output does not move.

Samples are taken on rising clock edges where the sample-enable input is high. The filtered level is registered, and it appears on the output directly after the edge that took the confirming sample. When sample enable is low, the filter holds its full state. This includes a change that is still waiting for its second sample.

A small four-state machine implements the filter. The state records the current output level, and whether one opposing sample has already been seen.

Top module: `gf_glitch_filter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets dout to 0 and clears any pending change. After reset, two enabled 1 samples are needed to raise dout.
- R2: While dout is 0, an enabled 1 sample that follows an enabled 0 sample (or follows reset) leaves dout at 0.
- R3: While dout is 1, an enabled 0 sample that follows an enabled 1 sample leaves dout at 1.
- R4: While dout is 0, two consecutive enabled samples of 1 set dout to 1 after the edge that takes the second sample.
- R5: While dout is 1, two consecutive enabled samples of 0 set dout to 0 after the edge that takes the second sample.
- R6: At an edge where sample_en is low, din is ignored and dout does not change. A pending first opposing sample is kept, so the next enabled sample of the same value completes the change.
- R7: dout only changes at an edge where the enabled sample equals the previous enabled sample. In that case dout takes that sample's value.
- R8: The enabled input sequence 0 1 0 0 1 1 0 1 1 0 0, applied from reset, gives the dout sequence 0 0 0 0 0 1 1 1 1 1 0. Each dout value is read after the edge of its sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | High marks the edge at which din is taken as a sample |
| din | input | 1 | Sampled input bit to be filtered |
| dout | output | 1 | Filtered, registered output level |

## Verification
The assertions assume that rst, sample_en and din are synchronous to clk, settled at each rising edge, and always 0 or 1. They also assume that reset is held for at least one edge before any checked behaviour begins. The bench changes every input only on the falling clock edge and drives only defined values. It asserts reset at the start and at one point mid-run. The enable pattern mixes long enabled runs with isolated and repeated gaps, including gaps that fall between the two samples of a pending change.

// File: rtl/gf_pkg.sv
package gf_pkg;

    // Bit 1 of the encoding is the output level; bit 0 marks a pending change.
    typedef enum logic [1:0] {
        GF_LOW       = 2'b00,
        GF_LOW_ARMED = 2'b01,
        GF_HIGH      = 2'b10,
        GF_HIGH_ARMED= 2'b11
    } gf_state_e;

    localparam gf_state_e GF_RESET_STATE = GF_LOW;

    function automatic logic gf_level(input gf_state_e s);
        return s[1];
    endfunction

    function automatic gf_state_e gf_step(input gf_state_e s, input logic d);
        gf_state_e n;
        unique case (s)
            GF_LOW:        n = d ? GF_LOW_ARMED : GF_LOW;
            GF_LOW_ARMED:  n = d ? GF_HIGH      : GF_LOW;
            GF_HIGH:       n = d ? GF_HIGH      : GF_HIGH_ARMED;
            GF_HIGH_ARMED: n = d ? GF_HIGH      : GF_LOW;
            default:       n = GF_RESET_STATE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/gf_next_logic.sv
module gf_next_logic
    import gf_pkg::*;
(
    input  gf_state_e cur_state,
    input  logic      sample_en,
    input  logic      din,
    output gf_state_e nxt_state
);

    always_comb begin
        if (sample_en) begin
            nxt_state = gf_step(cur_state, din);
        end else begin
            nxt_state = cur_state;
        end
    end

endmodule

// File: rtl/gf_state_reg.sv
module gf_state_reg
    import gf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gf_state_e nxt_state,
    output gf_state_e cur_state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= GF_RESET_STATE;
        end else begin
            cur_state <= nxt_state;
        end
    end

endmodule

// File: rtl/gf_glitch_filter.sv
module gf_glitch_filter
    import gf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic din,
    output logic dout
);

    gf_state_e state_q;
    gf_state_e state_d;

    gf_next_logic u_next (
        .cur_state (state_q),
        .sample_en (sample_en),
        .din       (din),
        .nxt_state (state_d)
    );

    gf_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    assign dout = gf_level(state_q);

endmodule

// File: rtl/gf_glitch_filter_chk.sv
module gf_glitch_filter_chk (
    input logic clk,
    input logic rst,
    input logic sample_en,
    input logic din,
    input logic dout
);

    // Last enabled sample seen at the ports; reset counts as a 0 history.
    logic last_smp;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_smp <= 1'b0;
        end else if (sample_en) begin
            last_smp <= din;
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk) rst |=> !dout);

    assert_lone_one_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_en && din && !last_smp) |=> $stable(dout));

    assert_lone_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !din && last_smp) |=> $stable(dout));

    assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (sample_en && din && last_smp) |=> dout);

    assert_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !din && !last_smp) |=> !dout);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(dout));

    assert_confirm_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_en && din == last_smp) |=> dout == $past(din));

endmodule

bind gf_glitch_filter gf_glitch_filter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .din       (din),
    .dout      (dout)
);

// File: tb/test_gf_glitch_filter.sv
module test_gf_glitch_filter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic din = 1'b0;
    logic dout;

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural reference: previous enabled sample and current level.
    int ref_prev = 0;
    int ref_out  = 0;

    always #10 clk = ~clk;

    gf_glitch_filter i_gf_glitch_filter (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .din       (din),
        .dout      (dout)
    );

    task automatic step(input logic r, input logic en, input logic d, input string req);
        rst = r; sample_en = en; din = d;
        @(posedge clk);
        if (r) begin
            ref_prev = 0; ref_out = 0;
        end else if (en) begin
            if (int'(d) == ref_prev) ref_out = int'(d);
            ref_prev = int'(d);
        end
        @(negedge clk);
        n_vec++;
        if (int'(dout) != ref_out) begin
            n_bad++;
            $display("FAIL %s: dout=%0d expected=%0d (t=%0t)", req, dout, ref_out, $time);
        end
    endtask

    task automatic run_seq(input string bits, input string req);
        for (int k = 0; k < bits.len(); k++) begin
            step(1'b0, 1'b1, bits[k] == "1", req);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R1: reset state
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
        // R8: example sequence from reset
        run_seq("01001101100", "R8");
        // R2: lone 1 in a run of 0s
        run_seq("0001000", "R2");
        // R4: two 1s raise
        run_seq("11", "R4");
        // R3: lone 0 in a run of 1s
        run_seq("1101111", "R3");
        // R5: two 0s lower
        run_seq("00", "R5");
        // R6: disabled edges ignore din and keep a pending change
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0, "R6");
        // R1: reset mid-run while high, then 1 alone must not raise
        run_seq("11", "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b1, "R1");
        // R7: pseudo-random stream with enable gaps
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[3] | lfsr[7], lfsr[0] ^ (lfsr[5] & lfsr[9]), "R7");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule